// File: doc/BRIEF.md
# Write-Only Serial Configuration Register Bank

This block is a receive-only two-wire serial slave that loads a bank of sixteen 8-bit parameter registers from a host controller. Both bus lines are brought into the fast system clock domain through two-flop synchronizers and their edges are found there. The slave recognises START and STOP conditions, accepts only its fixed address with the write direction bit, takes one subaddress byte and then stores data bytes. It never stretches the clock and never answers read transfers. SDA is driven only as an open-drain pull-down request.

A control byte inside the bank selects between two update styles. In immediate mode every data byte lands in its active register at once and a run of data bytes fills consecutive registers, the pointer wrapping from the last register to the first. In buffered mode a frame carries exactly one data byte, which is held in a shadow copy and moved into the active registers when a vertical-blanking strobe arrives; until that happens the slave refuses its own address. A few subaddresses are reserved: they are acknowledged but keep their reset value. A power-fail input returns every register, active and shadow, to 01h.

Top module: `cfg_i2c_bank`

## Requirements
- R1: After a synchronous reset (rst_n low) or a cycle with pwr_fail high, all sixteen registers on reg_q read 01h (register n at reg_q[8n+7:8n]), sda_pull is low, and an update that was waiting for blanking is dropped.
- R2: A START is SDA falling while SCL is high and a STOP is SDA rising while SCL is high; after a START the first byte (MSB first, sampled while SCL is high) equal to 88h is acknowledged by pulling SDA low during the ninth SCL pulse, and any other first byte is not acknowledged and the rest of that frame is ignored.
- R3: A subaddress byte from 00h to 0Fh is acknowledged; a larger value is not acknowledged and data bytes that follow in the same frame are neither acknowledged nor stored.
- R4: With the buffer-mode bit clear, each acknowledged data byte is written to its active register before the next SCL pulse, and successive data bytes go to successive subaddresses, wrapping from 0Fh to 00h.
- R5: Subaddresses 07h, 08h, 09h, 0Bh and 0Fh are acknowledged as data targets but their registers stay at 01h.
- R6: With the buffer-mode bit set, the first data byte of a frame is acknowledged and held without changing reg_q; any further data byte of that frame is not acknowledged and not stored.
- R7: After a buffered byte is held, the address byte 88h is not acknowledged until a vblank pulse; that pulse copies the held byte into reg_q and the address is acknowledged again from then on.
- R8: Flag outputs decode the active registers: mtx_alt is bit 0 and buf_mode is bit 1 of register 0Dh, cutoff_off is bit 0 of register 0Eh.
- R9: sda_pull only changes while the synchronised SCL is low.
- R10: A START in the middle of a frame abandons it, releases SDA and begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail | input | 1 | Synchronous power-fail reset of all registers to 01h |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| vblank | input | 1 | Single-cycle vertical-blanking strobe |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| reg_q | output | 128 | Active registers, register n at bits 8n+7:8n |
| mtx_alt | output | 1 | Bit 0 of register 0Dh |
| buf_mode | output | 1 | Bit 1 of register 0Dh, buffered update mode |
| cutoff_off | output | 1 | Bit 0 of register 0Eh |

## Verification
A wrong pointer, bit count or receive state shows up on the SDA line within the very next acknowledge slot, as a missing or extra pull-down, and on reg_q a few system clocks after that slot's falling SCL edge. A stuck or lost pending flag shows at the ports as a refused or accepted address byte in the next frame and as a copy that does or does not happen on the next vblank pulse. The bench therefore checks every acknowledge bit it clocks and reads reg_q between frames and around each blanking pulse.

// File: rtl/cfg_i2c_pkg.sv
// Package: shared types for the serial configuration register bank.
// Assumes a receive-only slave with a single byte-oriented frame decoder.
package cfg_i2c_pkg;

    // Receive states of the frame decoder.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_SUB,
        RX_DATA,
        RX_SKIP
    } rx_state_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/cfg_i2c_sync.sv
// Module: cfg_i2c_sync
// Brings SCL and SDA into the system clock domain through a flop chain of
// STAGES flops each, then derives single-cycle SCL edge pulses and START/STOP
// pulses. Assumes the system clock is many times faster than SCL so that
// both lines see the same chain delay. Reset value is the idle bus (high).
module cfg_i2c_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains for both bus lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    // One-cycle history of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition pulses.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/cfg_i2c_rx.sv
// Module: cfg_i2c_rx
// Frame decoder: shifts in bytes on rising SCL, decides on acknowledge at
// the falling edge that ends the eighth bit, holds SDA low for the ninth
// bit and issues one-cycle register write requests. Assumes NREG is a
// power of two so the subaddress pointer wraps by overflow.
module cfg_i2c_rx
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0]  SLAVE_ADDR = 7'b1000100,
    parameter int unsigned NREG       = 16,
    localparam int unsigned AW        = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              pend,
    input  logic              buf_mode,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [AW-1:0]     wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [BYTE_W-1:0] ADDR_BYTE = {SLAVE_ADDR, 1'b0};
    localparam logic [BYTE_W:0]   SUB_LIM   = (BYTE_W+1)'(NREG);

    rx_state_t         state;
    rx_state_t         nxt;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              in_ack;
    logic              first;
    logic              acc;
    logic [AW-1:0]     ptr;

    // Acknowledge decision for the byte just completed.
    always_comb begin
        acc = 1'b0;
        nxt = state;
        case (state)
            RX_ADDR: begin
                acc = (shreg == ADDR_BYTE) && !pend;
                nxt = acc ? RX_SUB : RX_SKIP;
            end
            RX_SUB: begin
                acc = ({1'b0, shreg} < SUB_LIM);
                nxt = acc ? RX_DATA : RX_SKIP;
            end
            RX_DATA: begin
                acc = first || !buf_mode;
                nxt = acc ? RX_DATA : RX_SKIP;
            end
            default: begin
                acc = 1'b0;
                nxt = state;
            end
        endcase
    end

    // Bit shifting, acknowledge slot and frame state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            first    <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= RX_ADDR;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= RX_IDLE;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (state != RX_IDLE) begin
                if (scl_rise && !in_ack && bitcnt < 4'd8) begin
                    shreg  <= {shreg[BYTE_W-2:0], sda_s};
                    bitcnt <= bitcnt + 4'd1;
                end else if (scl_fall && in_ack) begin
                    in_ack   <= 1'b0;
                    sda_pull <= 1'b0;
                    bitcnt   <= '0;
                end else if (scl_fall && bitcnt == 4'd8) begin
                    in_ack   <= 1'b1;
                    sda_pull <= acc;
                    state    <= nxt;
                    if (state == RX_SUB && acc) begin
                        ptr   <= shreg[AW-1:0];
                        first <= 1'b1;
                    end
                    if (state == RX_DATA && acc) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 1'b1;
                        first   <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cfg_i2c_regs.sv
// Module: cfg_i2c_regs
// Active and shadow register bank. Immediate writes update both copies;
// buffered writes update the shadow and raise a pending flag that a vblank
// strobe turns into a full shadow-to-active copy. Reserved entries (set bits
// of RSV_MASK) are constants and ignore writes. Assumes at most one write
// request per cycle.
module cfg_i2c_regs
    import cfg_i2c_pkg::*;
#(
    parameter int unsigned       NREG     = 16,
    parameter logic [NREG-1:0]   RSV_MASK = 16'h8B80,
    parameter logic [BYTE_W-1:0] RST_VAL  = 8'h01,
    localparam int unsigned      AW       = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_fail,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic                   buf_mode,
    input  logic                   vblank,
    output logic [NREG*BYTE_W-1:0] reg_q,
    output logic                   pend
);

    logic clr;
    logic store_buf;
    logic copy;

    // Common control terms.
    always_comb begin
        clr       = !rst_n || pwr_fail;
        store_buf = wr_en && buf_mode && !RSV_MASK[wr_idx];
        copy      = vblank && pend;
    end

    // Pending-update flag: set by a held byte, cleared by the blanking copy.
    always_ff @(posedge clk) begin
        if (clr) begin
            pend <= 1'b0;
        end else begin
            if (copy)      pend <= 1'b0;
            if (store_buf) pend <= 1'b1;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (RSV_MASK[i]) begin : g_rsv
            assign reg_q[i*BYTE_W +: BYTE_W] = RST_VAL;
        end else begin : g_live
            logic [BYTE_W-1:0] act;
            logic [BYTE_W-1:0] shd;
            logic              hit;

            assign hit = wr_en && (wr_idx == AW'(i));

            // Shadow copy follows every write to this entry.
            always_ff @(posedge clk) begin
                if (clr)      shd <= RST_VAL;
                else if (hit) shd <= wr_data;
            end

            // Active copy: immediate write or blanking-time copy.
            always_ff @(posedge clk) begin
                if (clr)                   act <= RST_VAL;
                else if (hit && !buf_mode) act <= wr_data;
                else if (copy)             act <= shd;
            end

            assign reg_q[i*BYTE_W +: BYTE_W] = act;
        end
    end

endmodule

// File: rtl/cfg_i2c_bank.sv
// Module: cfg_i2c_bank (top)
// Write-only serial slave loading a bank of parameter registers. Ties the
// synchronizer, the frame decoder and the register bank together and
// decodes the control flags. Assumes NREG is a power of two and that the
// control indices are not reserved.
module cfg_i2c_bank
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0]      SLAVE_ADDR = 7'b1000100,
    parameter int unsigned     NREG       = 16,
    parameter logic [NREG-1:0] RSV_MASK   = 16'h8B80,
    parameter int unsigned     SYNC_LEN   = 2,
    parameter int unsigned     CTRL_IDX   = 13,
    parameter int unsigned     FLAG_IDX   = 14,
    localparam int unsigned    AW         = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_fail,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   vblank,
    output logic                   sda_pull,
    output logic [NREG*BYTE_W-1:0] reg_q,
    output logic                   mtx_alt,
    output logic                   buf_mode,
    output logic                   cutoff_off
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              pend;
    logic              wr_en;
    logic [AW-1:0]     wr_idx;
    logic [BYTE_W-1:0] wr_data;

    cfg_i2c_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_i2c_rx #(.SLAVE_ADDR(SLAVE_ADDR), .NREG(NREG)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .pend      (pend),
        .buf_mode  (buf_mode),
        .sda_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    cfg_i2c_regs #(.NREG(NREG), .RSV_MASK(RSV_MASK), .RST_VAL(8'h01)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .buf_mode (buf_mode),
        .vblank   (vblank),
        .reg_q    (reg_q),
        .pend     (pend)
    );

    // Control flag decode from the active registers.
    always_comb begin
        mtx_alt    = reg_q[CTRL_IDX*BYTE_W + 0];
        buf_mode   = reg_q[CTRL_IDX*BYTE_W + 1];
        cutoff_off = reg_q[FLAG_IDX*BYTE_W + 0];
    end

endmodule

// File: rtl/cfg_i2c_bank_chk.sv
// Module: cfg_i2c_bank_chk
// Property checker bound to cfg_i2c_bank. Watches the ports together with
// the pulses and flags passed between the internal blocks.
module cfg_i2c_bank_chk #(
    parameter int unsigned NREG = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_fail,
    input logic            vblank,
    input logic            sda_pull,
    input logic [NREG*8-1:0] reg_q,
    input logic            scl_s,
    input logic            start_det,
    input logic            pend,
    input logic            wr_en,
    input logic            buf_mode
);

    AST_PWRFAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_fail) |-> (reg_q == {NREG{8'h01}}));   // R1

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);   // R9

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !vblank && !pwr_fail) |=> $stable(reg_q));   // R6

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && vblank) |=> !pend);   // R7

    AST_NO_WRITE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_mode) |-> !pend);   // R7

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull);   // R10

endmodule

bind cfg_i2c_bank cfg_i2c_bank_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .vblank    (vblank),
    .sda_pull  (sda_pull),
    .reg_q     (reg_q),
    .scl_s     (scl_s),
    .start_det (start_det),
    .pend      (pend),
    .wr_en     (wr_en),
    .buf_mode  (buf_mode)
);

// File: tb/cfg_i2c_bank_test.sv
`timescale 1ns/100ps
// Bench for cfg_i2c_bank: bit-banged host on an open-drain SDA model,
// a vector table of single-byte frames, then directed corner tests.
module cfg_i2c_bank_test;

    localparam int Q = 10;  // system clocks per quarter SCL period

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwr_fail = 1'b0;
    logic         vblank = 1'b0;
    logic         scl = 1'b1;
    logic         sda_host = 1'b1;
    logic         sda_line;
    logic         sda_pull;
    logic [127:0] reg_q;
    logic         mtx_alt;
    logic         buf_mode;
    logic         cutoff_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    assign sda_line = sda_host & ~sda_pull;

    always #2.5 clk = ~clk;

    cfg_i2c_bank uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_fail   (pwr_fail),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .vblank     (vblank),
        .sda_pull   (sda_pull),
        .reg_q      (reg_q),
        .mtx_alt    (mtx_alt),
        .buf_mode   (buf_mode),
        .cutoff_off (cutoff_off)
    );

    // Vector entries: {subaddress, data, expected sub ack, expected stored}
    localparam int NV = 8;
    localparam logic [17:0] VEC [NV] = '{
        {8'h00, 8'h11, 1'b1, 1'b1},
        {8'h01, 8'h22, 1'b1, 1'b1},
        {8'h07, 8'h44, 1'b1, 1'b0},
        {8'h0B, 8'h55, 1'b1, 1'b0},
        {8'h0A, 8'h66, 1'b1, 1'b1},
        {8'h20, 8'h77, 1'b0, 1'b0},
        {8'hFF, 8'h12, 1'b0, 1'b0},
        {8'h0C, 8'h9C, 1'b1, 1'b1}
    };

    function automatic logic [7:0] rd(input int i);
        return reg_q[i*8 +: 8];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_host = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        sda_host = 1'b0; tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic bus_stop;
        sda_host = 1'b0; tick(Q);
        scl = 1'b1;      tick(Q);
        sda_host = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int k = 7; k >= 0; k--) begin
            sda_host = b[k]; tick(Q);
            scl = 1'b1;      tick(2*Q);
            scl = 1'b0;      tick(Q);
        end
        sda_host = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic frame(input logic [7:0] sub, input logic [7:0] d,
                         output logic a0, output logic a1, output logic a2);
        bus_start;
        put_byte(8'h88, a0);
        put_byte(sub, a1);
        put_byte(d, a2);
        bus_stop;
    endtask

    task automatic pulse_vblank;
        vblank = 1'b1; tick(1);
        vblank = 1'b0; tick(2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%h exp=%h", 8'h0, 8'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic a0, a1, a2, a3;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        for (int i = 0; i < 16; i++) chk($sformatf("R1 reset reg %0d", i), rd(i), 8'h01);
        chk("R1 sda released", {7'd0, sda_pull}, 8'h00);
        chk("R8 flags after reset", {5'd0, cutoff_off, buf_mode, mtx_alt}, 8'h05);

        // Vector table: single-byte immediate frames (R2, R3, R4, R5)
        for (int v = 0; v < NV; v++) begin
            logic [7:0] sb, dt, ex;
            sb = VEC[v][17:10];
            dt = VEC[v][9:2];
            frame(sb, dt, a0, a1, a2);
            tick(4);
            chk($sformatf("R2 addr ack v%0d", v), {7'd0, a0}, 8'h01);
            chk($sformatf("R3 sub ack v%0d", v), {7'd0, a1}, {7'd0, VEC[v][1]});
            if (!VEC[v][1]) begin
                chk($sformatf("R3 data nack v%0d", v), {7'd0, a2}, 8'h00);
            end else begin
                ex = VEC[v][0] ? dt : 8'h01;
                chk($sformatf("R4/R5 reg v%0d", v), rd(int'(sb)), ex);
            end
        end

        // R2: wrong address byte ignored for the whole frame
        bus_start;
        put_byte(8'h8A, a0);
        put_byte(8'h02, a1);
        put_byte(8'hEE, a2);
        bus_stop;
        tick(4);
        chk("R2 wrong addr nack", {5'd0, a0, a1, a2}, 8'h00);
        chk("R2 wrong addr no store", rd(2), 8'h01);

        // R4 + R5 + R8: burst with wrap from 0E through 0F to 00 and 01
        bus_start;
        put_byte(8'h88, a0);
        put_byte(8'h0E, a1);
        put_byte(8'hA5, a2);
        put_byte(8'h3C, a3);
        chk("R5 reserved 0F acked", {7'd0, a3}, 8'h01);
        put_byte(8'h5E, a3);
        chk("R4 wrap byte ack", {7'd0, a3}, 8'h01);
        put_byte(8'h6F, a3);
        bus_stop;
        tick(4);
        chk("R4 burst first", rd(14), 8'hA5);
        chk("R5 burst reserved 0F", rd(15), 8'h01);
        chk("R4 wrap to 00", rd(0), 8'h5E);
        chk("R4 wrap to 01", rd(1), 8'h6F);
        chk("R8 cutoff flag", {7'd0, cutoff_off}, 8'h01);

        // R10: repeated start abandons the first frame
        bus_start;
        put_byte(8'h88, a0);
        put_byte(8'h05, a1);
        bus_start;
        put_byte(8'h88, a0);
        put_byte(8'h06, a1);
        put_byte(8'h33, a2);
        bus_stop;
        tick(4);
        chk("R10 restart addr ack", {6'd0, a0, a1}, 8'h03);
        chk("R10 restart target", rd(6), 8'h33);
        chk("R10 abandoned target", rd(5), 8'h01);

        // R8: enter buffered mode (register 0D bit 1), matrix bit 0 cleared
        frame(8'h0D, 8'h02, a0, a1, a2);
        tick(4);
        chk("R8 buf_mode set", {6'd0, buf_mode, mtx_alt}, 8'h02);

        // R6: one byte held, second refused
        bus_start;
        put_byte(8'h88, a0);
        put_byte(8'h03, a1);
        put_byte(8'h5A, a2);
        put_byte(8'h77, a3);
        bus_stop;
        tick(4);
        chk("R6 first byte ack", {7'd0, a2}, 8'h01);
        chk("R6 second byte nack", {7'd0, a3}, 8'h00);
        chk("R6 active held", rd(3), 8'h01);
        chk("R6 next reg untouched", rd(4), 8'h01);

        // R7: address refused while pending, copy on vblank
        frame(8'h02, 8'h99, a0, a1, a2);
        tick(4);
        chk("R7 addr nack pending", {7'd0, a0}, 8'h00);
        chk("R7 no store pending", rd(2), 8'h01);
        pulse_vblank;
        chk("R7 copied on vblank", rd(3), 8'h5A);
        chk("R6 second byte not stored", rd(4), 8'h01);
        frame(8'h0D, 8'h01, a0, a1, a2);
        tick(4);
        chk("R7 addr ack after copy", {7'd0, a0}, 8'h01);
        chk("R7 mode change held", {6'd0, buf_mode, mtx_alt}, 8'h02);
        pulse_vblank;
        chk("R8 back to immediate", {6'd0, buf_mode, mtx_alt}, 8'h01);

        // R1: power-fail returns everything to 01h
        pwr_fail = 1'b1; tick(1);
        pwr_fail = 1'b0; tick(2);
        for (int i = 0; i < 16; i++) chk($sformatf("R1 pwr_fail reg %0d", i), rd(i), 8'h01);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule